// File: doc/BRIEF.md
# Guest Event Injection Arbiter

This block picks, at each guest-entry strobe, the one event to hand to the guest, and builds the words that describe it. An exception, an NMI or a maskable interrupt can be waiting at the same time. Events that were interrupted in flight are always re-delivered before anything new is looked at. A new NMI is gated by the guest's interrupt-shadow and NMI-blocking state. If virtual NMI support is absent, a software NMI-block flag is kept as well. When a waiting event cannot go in yet, the block asks the entry logic to open an NMI window or an interrupt window.

The result of each strobe is registered: an event-information word, an error code, an entry instruction length and an adjusted return address. In real mode every event is rewritten into a software interrupt of length one, and the return address is backed up by one byte. The block also holds the STI and MOV-SS shadow bits and the virtual NMI-blocked bit. A skip of an emulated instruction advances the return address and clears both shadows.

Top module: `evt_inject_arb`

## Requirements
- R1: On a strobe, the first of these that is present is chosen: pending exception (`exc_pend_i`), NMI already being injected, queued interrupt (`irq_q_pend_i`), then a new event. Only one event is injected per strobe.
- R2: A pending new NMI takes precedence over a new interrupt. While an NMI is pending, no new interrupt is injected even if the NMI is blocked. Injecting a new NMI moves it from pending to in-flight. It stays in flight, and is re-delivered, until `nmi_done_i` is pulsed.
- R3: A new NMI is allowed only if the MOV-SS shadow is clear and the virtual NMI-blocked bit is clear. When `vnmi_sup_i`=0, the software NMI-block flag must also be clear.
- R4: Exception vectors 3 and 4 get type 6 (software exception) and carry `exit_len_i` as the length. Every other exception vector gets type 3 (hardware exception) with length 0.
- R5: When `exc_has_err_i` is set, `err_o` carries `exc_err_i` and info bit 11 is 1. Otherwise both are 0.
- R6: In real mode (`real_mode_i`=1), any injected event gets type 4 with length 1. `rip_o` = `rip_i` + `exit_len_i` − 1 for exceptions 3 and 4 and for soft queued interrupts, and `rip_i` − 1 for all other events. Outside real mode `rip_o` = `rip_i`.
- R7: An NMI has vector 2 and type 2. A queued interrupt has type 0, or type 4 with length `exit_len_i` when `irq_q_soft_i` is set. A new interrupt has type 0 and vector `irq_new_vec_i`.
- R8: A strobe that leaves an NMI pending raises `nmi_win_o` if `vnmi_sup_i`=1, and `irq_win_o` if `vnmi_sup_i`=0. With no NMI left pending, `irq_win_o` is raised when `irq_new_i` is set but that interrupt was not taken. The windows are registered on each strobe.
- R9: `skip_i` sets `rip_o` to `rip_i` + `exit_len_i` and clears both shadow bits one cycle later.
- R10: Injecting an NMI (new or re-delivered) with `vnmi_sup_i`=0 sets the software block flag and zeroes `blk_cyc_o`. `blk_cyc_o` then rises by one per clock, saturating, while the flag is set.
- R11: The info word has the vector in bits 7:0, the type in bits 10:8, deliver-error-code in bit 11 and valid in bit 31. All other bits are 0. Outputs change only on a strobe (or a skip, for `rip_o`). A strobe with nothing eligible gives an all-zero info word. Reset clears every output.
- R12: `shadow_wr_i` loads the STI and MOV-SS shadow bits. `nmi_mask_wr_i` loads `nmi_mask_i` into the virtual NMI-blocked bit if `vnmi_sup_i`=1, and into the software block flag otherwise. If the software flag changes, `blk_cyc_o` is zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| inject_i | input | 1 | Single-cycle injection strobe |
| exc_pend_i | input | 1 | Exception waiting for delivery |
| exc_vec_i | input | 8 | Exception vector |
| exc_has_err_i | input | 1 | Exception carries an error code |
| exc_err_i | input | ERR_W | Exception error code |
| nmi_raise_i | input | 1 | Make an NMI pending |
| nmi_done_i | input | 1 | In-flight NMI delivery completed |
| irq_q_pend_i | input | 1 | Interrupt already queued for delivery |
| irq_q_vec_i | input | 8 | Queued interrupt vector |
| irq_q_soft_i | input | 1 | Queued interrupt is a software interrupt |
| irq_new_i | input | 1 | New maskable interrupt available |
| irq_new_vec_i | input | 8 | New interrupt vector |
| irq_ok_i | input | 1 | Guest accepts maskable interrupts |
| exit_len_i | input | LEN_W | Exit instruction length |
| vnmi_sup_i | input | 1 | Virtual NMI support strap |
| real_mode_i | input | 1 | Guest runs in real mode |
| rip_i | input | RIP_W | Current guest return address |
| skip_i | input | 1 | Skip the emulated instruction |
| shadow_wr_i | input | 1 | Load interrupt-shadow bits |
| shadow_sti_i | input | 1 | STI shadow value |
| shadow_movss_i | input | 1 | MOV-SS shadow value |
| nmi_mask_wr_i | input | 1 | Load NMI mask |
| nmi_mask_i | input | 1 | NMI mask value |
| info_o | output | 32 | Event-information word |
| err_o | output | ERR_W | Error code to deliver |
| ilen_o | output | LEN_W | Entry instruction length |
| rip_o | output | RIP_W | Adjusted return address |
| irq_win_o | output | 1 | Interrupt-window request |
| nmi_win_o | output | 1 | NMI-window request |
| sti_sh_o | output | 1 | STI shadow state |
| movss_sh_o | output | 1 | MOV-SS shadow state |
| nmi_blk_o | output | 1 | Virtual NMI-blocked bit |
| soft_nmi_blk_o | output | 1 | Software NMI-block flag |
| blk_cyc_o | output | CNT_W | Cycles spent in software NMI block |

## Verification
The arbiter is driven with several overlapping sets of pending events: exception with queued and new interrupts, in-flight NMI with a queued interrupt, and new NMI with a new interrupt. Each set shows which level of the fixed order wins. NMI gating is tried against each blocker on its own (MOV-SS shadow, virtual blocked bit, software flag). The blocked strobes show whether a pending NMI holds back interrupts and which window request comes out, with and without virtual NMI support. Exception vectors 3, 4 and an ordinary one are applied in both protected and real mode, with and without an error code. These separate the type, length and return-address rules.

// File: rtl/evt_inject_pkg.sv
package evt_inject_pkg;

    localparam int VEC_W  = 8;
    localparam int INFO_W = 32;
    localparam logic [VEC_W-1:0] NMI_VEC = 8'd2;
    localparam logic [VEC_W-1:0] BP_VEC  = 8'd3;
    localparam logic [VEC_W-1:0] OF_VEC  = 8'd4;

    typedef enum logic [2:0] {
        TY_EXT   = 3'd0,
        TY_NMI   = 3'd2,
        TY_HWEXC = 3'd3,
        TY_SWINT = 3'd4,
        TY_SWEXC = 3'd6
    } evt_type_e;

    typedef enum logic [2:0] {
        SRC_NONE    = 3'd0,
        SRC_EXC     = 3'd1,
        SRC_NMI_RE  = 3'd2,
        SRC_IRQ_RE  = 3'd3,
        SRC_NMI_NEW = 3'd4,
        SRC_IRQ_NEW = 3'd5
    } src_e;

    localparam int NSRC = 5;

endpackage

// File: rtl/evt_inject_sel.sv
module evt_inject_sel
    import evt_inject_pkg::*;
(
    input  logic            exc_pend_i,
    input  logic            nmi_inj_i,
    input  logic            irq_q_i,
    input  logic            nmi_pend_i,
    input  logic            nmi_ok_i,
    input  logic            irq_new_i,
    input  logic            irq_ok_i,
    output src_e            src_o,
    output logic [NSRC-1:0] grant_o
);

    logic [NSRC-1:0] req;
    logic            taken;

    always_comb begin
        req[0] = exc_pend_i;
        req[1] = nmi_inj_i;
        req[2] = irq_q_i;
        req[3] = nmi_pend_i && nmi_ok_i;
        req[4] = !nmi_pend_i && irq_new_i && irq_ok_i;
        taken  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            grant_o[i] = req[i] && !taken;
            taken      = taken || req[i];
        end
        unique case (1'b1)
            grant_o[0]: src_o = SRC_EXC;
            grant_o[1]: src_o = SRC_NMI_RE;
            grant_o[2]: src_o = SRC_IRQ_RE;
            grant_o[3]: src_o = SRC_NMI_NEW;
            grant_o[4]: src_o = SRC_IRQ_NEW;
            default:    src_o = SRC_NONE;
        endcase
    end

    always_comb begin
        AST_ONE_GRANT: assert ($onehot0(grant_o));                     // R1
        AST_NMI_HOLDS_IRQ: assert (!(grant_o[4] && nmi_pend_i));       // R2
    end

endmodule

// File: rtl/evt_inject_fmt.sv
module evt_inject_fmt
    import evt_inject_pkg::*;
#(
    parameter int RIP_W = 32,
    parameter int ERR_W = 32,
    parameter int LEN_W = 4
) (
    input  src_e              src_i,
    input  logic [VEC_W-1:0]  exc_vec_i,
    input  logic              exc_has_err_i,
    input  logic [ERR_W-1:0]  exc_err_i,
    input  logic [VEC_W-1:0]  irq_q_vec_i,
    input  logic              irq_q_soft_i,
    input  logic [VEC_W-1:0]  irq_new_vec_i,
    input  logic [LEN_W-1:0]  exit_len_i,
    input  logic              real_mode_i,
    input  logic [RIP_W-1:0]  rip_i,
    output logic [INFO_W-1:0] info_o,
    output logic [ERR_W-1:0]  err_o,
    output logic [LEN_W-1:0]  ilen_o,
    output logic [RIP_W-1:0]  rip_o
);

    localparam int PAD_W = INFO_W - VEC_W - 3 - 1 - 1;

    logic [VEC_W-1:0] vec;
    evt_type_e        ty;
    logic             soft_adv;
    logic             has_err;
    logic             valid;

    always_comb begin
        vec      = '0;
        ty       = TY_EXT;
        soft_adv = 1'b0;
        has_err  = 1'b0;
        valid    = 1'b1;
        ilen_o   = '0;
        unique case (src_i)
            SRC_EXC: begin
                vec     = exc_vec_i;
                has_err = exc_has_err_i;
                if (exc_vec_i == BP_VEC || exc_vec_i == OF_VEC) begin
                    ty       = TY_SWEXC;
                    ilen_o   = exit_len_i;
                    soft_adv = 1'b1;
                end else begin
                    ty = TY_HWEXC;
                end
            end
            SRC_NMI_RE, SRC_NMI_NEW: begin
                vec = NMI_VEC;
                ty  = TY_NMI;
            end
            SRC_IRQ_RE: begin
                vec = irq_q_vec_i;
                if (irq_q_soft_i) begin
                    ty       = TY_SWINT;
                    ilen_o   = exit_len_i;
                    soft_adv = 1'b1;
                end
            end
            SRC_IRQ_NEW: vec = irq_new_vec_i;
            default:     valid = 1'b0;
        endcase

        rip_o = rip_i;
        if (real_mode_i && valid) begin
            ty     = TY_SWINT;
            ilen_o = LEN_W'(1);
            rip_o  = rip_i + (soft_adv ? RIP_W'(exit_len_i) : '0) - RIP_W'(1);
        end

        info_o = {valid, {PAD_W{1'b0}}, has_err, ty, vec};
        err_o  = has_err ? exc_err_i : '0;
    end

    always_comb begin
        AST_INVALID_EMPTY: assert (valid || info_o == '0);             // R11
    end

endmodule

// File: rtl/evt_inject_arb.sv
module evt_inject_arb
    import evt_inject_pkg::*;
#(
    parameter int RIP_W = 32,
    parameter int ERR_W = 32,
    parameter int LEN_W = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject_i,
    input  logic              exc_pend_i,
    input  logic [7:0]        exc_vec_i,
    input  logic              exc_has_err_i,
    input  logic [ERR_W-1:0]  exc_err_i,
    input  logic              nmi_raise_i,
    input  logic              nmi_done_i,
    input  logic              irq_q_pend_i,
    input  logic [7:0]        irq_q_vec_i,
    input  logic              irq_q_soft_i,
    input  logic              irq_new_i,
    input  logic [7:0]        irq_new_vec_i,
    input  logic              irq_ok_i,
    input  logic [LEN_W-1:0]  exit_len_i,
    input  logic              vnmi_sup_i,
    input  logic              real_mode_i,
    input  logic [RIP_W-1:0]  rip_i,
    input  logic              skip_i,
    input  logic              shadow_wr_i,
    input  logic              shadow_sti_i,
    input  logic              shadow_movss_i,
    input  logic              nmi_mask_wr_i,
    input  logic              nmi_mask_i,
    output logic [31:0]       info_o,
    output logic [ERR_W-1:0]  err_o,
    output logic [LEN_W-1:0]  ilen_o,
    output logic [RIP_W-1:0]  rip_o,
    output logic              irq_win_o,
    output logic              nmi_win_o,
    output logic              sti_sh_o,
    output logic              movss_sh_o,
    output logic              nmi_blk_o,
    output logic              soft_nmi_blk_o,
    output logic [CNT_W-1:0]  blk_cyc_o
);

    typedef struct packed {
        logic [INFO_W-1:0] info;
        logic [ERR_W-1:0]  err;
        logic [LEN_W-1:0]  ilen;
        logic [RIP_W-1:0]  rip;
        logic              irq_win;
        logic              nmi_win;
        logic              sti;
        logic              movss;
        logic              nmi_blk;
        logic              soft_blk;
        logic              nmi_pend;
        logic              nmi_inj;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t s_d, s_q;

    src_e              src;
    logic [NSRC-1:0]   grant;
    logic              nmi_ok;
    logic              nmi_left;
    logic [INFO_W-1:0] f_info;
    logic [ERR_W-1:0]  f_err;
    logic [LEN_W-1:0]  f_len;
    logic [RIP_W-1:0]  f_rip;

    assign nmi_ok = !s_q.movss && !s_q.nmi_blk && (vnmi_sup_i || !s_q.soft_blk);

    evt_inject_sel u_sel (
        .exc_pend_i (exc_pend_i),
        .nmi_inj_i  (s_q.nmi_inj),
        .irq_q_i    (irq_q_pend_i),
        .nmi_pend_i (s_q.nmi_pend),
        .nmi_ok_i   (nmi_ok),
        .irq_new_i  (irq_new_i),
        .irq_ok_i   (irq_ok_i),
        .src_o      (src),
        .grant_o    (grant)
    );

    evt_inject_fmt #(
        .RIP_W (RIP_W),
        .ERR_W (ERR_W),
        .LEN_W (LEN_W)
    ) u_fmt (
        .src_i         (src),
        .exc_vec_i     (exc_vec_i),
        .exc_has_err_i (exc_has_err_i),
        .exc_err_i     (exc_err_i),
        .irq_q_vec_i   (irq_q_vec_i),
        .irq_q_soft_i  (irq_q_soft_i),
        .irq_new_vec_i (irq_new_vec_i),
        .exit_len_i    (exit_len_i),
        .real_mode_i   (real_mode_i),
        .rip_i         (rip_i),
        .info_o        (f_info),
        .err_o         (f_err),
        .ilen_o        (f_len),
        .rip_o         (f_rip)
    );

    assign nmi_left = s_q.nmi_pend && (src != SRC_NMI_NEW);

    always_comb begin
        s_d = s_q;
        if (s_q.soft_blk && s_q.cnt != '1)
            s_d.cnt = s_q.cnt + CNT_W'(1);
        if (nmi_done_i)
            s_d.nmi_inj = 1'b0;
        if (shadow_wr_i) begin
            s_d.sti   = shadow_sti_i;
            s_d.movss = shadow_movss_i;
        end
        if (skip_i) begin
            s_d.sti   = 1'b0;
            s_d.movss = 1'b0;
            s_d.rip   = rip_i + RIP_W'(exit_len_i);
        end
        if (nmi_mask_wr_i) begin
            if (vnmi_sup_i) begin
                s_d.nmi_blk = nmi_mask_i;
            end else if (s_q.soft_blk != nmi_mask_i) begin
                s_d.soft_blk = nmi_mask_i;
                s_d.cnt      = '0;
            end
        end
        if (inject_i) begin
            s_d.info    = f_info;
            s_d.err     = f_err;
            s_d.ilen    = f_len;
            s_d.rip     = f_rip;
            s_d.nmi_win = nmi_left && vnmi_sup_i;
            s_d.irq_win = (nmi_left && !vnmi_sup_i) ||
                          (!nmi_left && irq_new_i && src != SRC_IRQ_NEW);
            if (src == SRC_NMI_NEW) begin
                s_d.nmi_pend = 1'b0;
                s_d.nmi_inj  = 1'b1;
            end
            if ((src == SRC_NMI_NEW || src == SRC_NMI_RE) && !vnmi_sup_i) begin
                s_d.soft_blk = 1'b1;
                s_d.cnt      = '0;
            end
        end
        if (nmi_raise_i)
            s_d.nmi_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign info_o         = s_q.info;
    assign err_o          = s_q.err;
    assign ilen_o         = s_q.ilen;
    assign rip_o          = s_q.rip;
    assign irq_win_o      = s_q.irq_win;
    assign nmi_win_o      = s_q.nmi_win;
    assign sti_sh_o       = s_q.sti;
    assign movss_sh_o     = s_q.movss;
    assign nmi_blk_o      = s_q.nmi_blk;
    assign soft_nmi_blk_o = s_q.soft_blk;
    assign blk_cyc_o      = s_q.cnt;

    AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        inject_i && exc_pend_i |=> info_o[31] && info_o[7:0] == $past(exc_vec_i)); // R1
    AST_NMI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        inject_i && movss_sh_o && !exc_pend_i && !irq_q_pend_i && !s_q.nmi_inj
        |=> !(info_o[31] && info_o[10:8] == 3'd2)); // R3
    AST_REAL_SWINT: assert property (@(posedge clk) disable iff (!rst_n)
        inject_i && real_mode_i && (exc_pend_i || irq_q_pend_i)
        |=> ilen_o == LEN_W'(1) && info_o[10:8] == 3'd4); // R6
    AST_NO_NMI_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        inject_i && !vnmi_sup_i |=> !nmi_win_o); // R8
    AST_SKIP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        skip_i |=> !sti_sh_o && !movss_sh_o); // R9
    AST_HOLD_INFO: assert property (@(posedge clk) disable iff (!rst_n)
        !inject_i |=> $stable(info_o)); // R11

endmodule

// File: tb/evt_inject_arb_bench.sv
module evt_inject_arb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inject_i = 0, exc_pend_i = 0, exc_has_err_i = 0;
    logic [7:0]  exc_vec_i = 0, irq_q_vec_i = 0, irq_new_vec_i = 0;
    logic [31:0] exc_err_i = 0, rip_i = 0;
    logic        nmi_raise_i = 0, nmi_done_i = 0, irq_q_pend_i = 0, irq_q_soft_i = 0;
    logic        irq_new_i = 0, irq_ok_i = 0, vnmi_sup_i = 1, real_mode_i = 0;
    logic [3:0]  exit_len_i = 0;
    logic        skip_i = 0, shadow_wr_i = 0, shadow_sti_i = 0, shadow_movss_i = 0;
    logic        nmi_mask_wr_i = 0, nmi_mask_i = 0;
    logic [31:0] info_o, err_o, rip_o;
    logic [3:0]  ilen_o;
    logic        irq_win_o, nmi_win_o, sti_sh_o, movss_sh_o, nmi_blk_o, soft_nmi_blk_o;
    logic [15:0] blk_cyc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_inject_arb u_evt_inject_arb (
        .clk(clk), .rst_n(rst_n), .inject_i(inject_i),
        .exc_pend_i(exc_pend_i), .exc_vec_i(exc_vec_i), .exc_has_err_i(exc_has_err_i),
        .exc_err_i(exc_err_i), .nmi_raise_i(nmi_raise_i), .nmi_done_i(nmi_done_i),
        .irq_q_pend_i(irq_q_pend_i), .irq_q_vec_i(irq_q_vec_i), .irq_q_soft_i(irq_q_soft_i),
        .irq_new_i(irq_new_i), .irq_new_vec_i(irq_new_vec_i), .irq_ok_i(irq_ok_i),
        .exit_len_i(exit_len_i), .vnmi_sup_i(vnmi_sup_i), .real_mode_i(real_mode_i),
        .rip_i(rip_i), .skip_i(skip_i), .shadow_wr_i(shadow_wr_i),
        .shadow_sti_i(shadow_sti_i), .shadow_movss_i(shadow_movss_i),
        .nmi_mask_wr_i(nmi_mask_wr_i), .nmi_mask_i(nmi_mask_i),
        .info_o(info_o), .err_o(err_o), .ilen_o(ilen_o), .rip_o(rip_o),
        .irq_win_o(irq_win_o), .nmi_win_o(nmi_win_o), .sti_sh_o(sti_sh_o),
        .movss_sh_o(movss_sh_o), .nmi_blk_o(nmi_blk_o), .soft_nmi_blk_o(soft_nmi_blk_o),
        .blk_cyc_o(blk_cyc_o)
    );

    function automatic logic [31:0] iw(input logic [7:0] v, input logic [2:0] ty,
                                        input logic e);
        return {1'b1, 19'b0, e, ty, v};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one-cycle strobe driven at a falling edge; outputs sampled at the next falling edge
    task automatic strobe();
        inject_i = 1'b1;
        @(negedge clk);
        inject_i = 1'b0;
    endtask

    task automatic pulse_done();
        nmi_done_i = 1'b1;
        @(negedge clk);
        nmi_done_i = 1'b0;
    endtask

    task automatic raise_nmi();
        nmi_raise_i = 1'b1;
        @(negedge clk);
        nmi_raise_i = 1'b0;
    endtask

    task automatic clear_ins();
        exc_pend_i = 0; exc_has_err_i = 0; irq_q_pend_i = 0; irq_q_soft_i = 0;
        irq_new_i = 0; irq_ok_i = 0; real_mode_i = 0; exit_len_i = 0;
    endtask

    task automatic t_reset();
        chk("R11 reset info", info_o, 0);
        chk("R11 reset windows", {irq_win_o, nmi_win_o}, 0);
        chk("R11 reset shadows", {sti_sh_o, movss_sh_o, nmi_blk_o, soft_nmi_blk_o}, 0);
        chk("R11 reset count", blk_cyc_o, 0);
    endtask

    task automatic t_exceptions();
        clear_ins(); rip_i = 32'h500; exit_len_i = 4'd5;
        exc_pend_i = 1; exc_vec_i = 8'd13; exc_has_err_i = 1; exc_err_i = 32'hBEEF;
        strobe();
        chk("R4 R5 hw exc info", info_o, iw(8'd13, 3'd3, 1'b1));
        chk("R5 err code", err_o, 32'hBEEF);
        chk("R4 hw exc len", ilen_o, 0);
        chk("R6 rip unchanged", rip_o, 32'h500);
        exc_has_err_i = 0; exc_vec_i = 8'd3; exit_len_i = 4'd2;
        strobe();
        chk("R4 bp soft exc", info_o, iw(8'd3, 3'd6, 1'b0));
        chk("R4 bp len", ilen_o, 2);
        chk("R5 no err", err_o, 0);
        exc_vec_i = 8'd4; exit_len_i = 4'd7;
        strobe();
        chk("R4 of soft exc", {info_o, 28'b0, ilen_o}, {iw(8'd4, 3'd6, 1'b0), 32'd7});
    endtask

    task automatic t_priority();
        clear_ins(); vnmi_sup_i = 1;
        exc_pend_i = 1; exc_vec_i = 8'd6; irq_q_pend_i = 1; irq_q_vec_i = 8'h40;
        irq_new_i = 1; irq_ok_i = 1; irq_new_vec_i = 8'h50;
        raise_nmi();
        strobe();
        chk("R1 exception first", info_o, iw(8'd6, 3'd3, 1'b0));
        chk("R8 nmi still pending", {nmi_win_o, irq_win_o}, 2'b10);
        exc_pend_i = 0;
        strobe();
        chk("R1 queued irq over new nmi", info_o, iw(8'h40, 3'd0, 1'b0));
        irq_q_pend_i = 0;
        strobe();
        chk("R2 R7 new nmi over new irq", info_o, iw(8'd2, 3'd2, 1'b0));
        chk("R8 irq window after nmi", {nmi_win_o, irq_win_o}, 2'b01);
        irq_q_pend_i = 1;
        strobe();
        chk("R1 in-flight nmi before queued irq", info_o, iw(8'd2, 3'd2, 1'b0));
        pulse_done();
        irq_q_soft_i = 1; exit_len_i = 4'd3;
        strobe();
        chk("R2 R7 soft queued irq", {info_o, 28'b0, ilen_o}, {iw(8'h40, 3'd4, 1'b0), 32'd3});
        irq_q_pend_i = 0; irq_q_soft_i = 0;
        strobe();
        chk("R7 new irq external", info_o, iw(8'h50, 3'd0, 1'b0));
        chk("R8 no window when irq taken", {nmi_win_o, irq_win_o}, 2'b00);
        irq_ok_i = 0;
        strobe();
        chk("R8 irq window when not allowed", {info_o[31], irq_win_o}, 2'b01);
    endtask

    task automatic t_nmi_gate();
        clear_ins(); vnmi_sup_i = 1; irq_new_i = 1; irq_ok_i = 1; irq_new_vec_i = 8'h33;
        shadow_wr_i = 1; shadow_movss_i = 1; shadow_sti_i = 0;
        @(negedge clk); shadow_wr_i = 0;
        chk("R12 movss loaded", {sti_sh_o, movss_sh_o}, 2'b01);
        raise_nmi();
        strobe();
        chk("R3 R2 movss blocks nmi and irq", info_o, 0);
        chk("R8 nmi window with vnmi", {nmi_win_o, irq_win_o}, 2'b10);
        shadow_wr_i = 1; shadow_movss_i = 0; nmi_mask_wr_i = 1; nmi_mask_i = 1;
        @(negedge clk); shadow_wr_i = 0; nmi_mask_wr_i = 0;
        chk("R12 vnmi mask bit", {nmi_blk_o, soft_nmi_blk_o}, 2'b10);
        strobe();
        chk("R3 blocked bit blocks nmi", info_o, 0);
        nmi_mask_wr_i = 1; nmi_mask_i = 0;
        @(negedge clk); nmi_mask_wr_i = 0;
        strobe();
        chk("R3 nmi once unblocked", info_o, iw(8'd2, 3'd2, 1'b0));
        pulse_done();
    endtask

    task automatic t_soft_block();
        clear_ins(); vnmi_sup_i = 0;
        raise_nmi();
        strobe();
        chk("R10 nmi without vnmi", info_o, iw(8'd2, 3'd2, 1'b0));
        chk("R10 soft flag set", {soft_nmi_blk_o, nmi_blk_o}, 2'b10);
        chk("R10 counter zeroed", blk_cyc_o, 0);
        repeat (5) @(negedge clk);
        chk("R10 counter counts", blk_cyc_o, 5);
        pulse_done();
        raise_nmi();
        strobe();
        chk("R3 soft flag blocks nmi", info_o, 0);
        chk("R8 irq window instead of nmi window", {nmi_win_o, irq_win_o}, 2'b01);
        nmi_mask_wr_i = 1; nmi_mask_i = 0;
        @(negedge clk); nmi_mask_wr_i = 0;
        chk("R12 soft flag cleared", {soft_nmi_blk_o, blk_cyc_o}, 17'd0);
        strobe();
        chk("R3 nmi after soft clear", info_o, iw(8'd2, 3'd2, 1'b0));
        pulse_done();
        nmi_mask_wr_i = 1; nmi_mask_i = 0;
        @(negedge clk); nmi_mask_wr_i = 0;
        vnmi_sup_i = 1;
    endtask

    task automatic t_real_mode();
        clear_ins(); real_mode_i = 1; rip_i = 32'h1000; exit_len_i = 4'd2;
        exc_pend_i = 1; exc_vec_i = 8'd3;
        strobe();
        chk("R6 real bp info", info_o, iw(8'd3, 3'd4, 1'b0));
        chk("R6 real len", ilen_o, 1);
        chk("R6 real bp rip", rip_o, 32'h1001);
        exc_vec_i = 8'd14; exc_has_err_i = 1; exc_err_i = 32'h7;
        strobe();
        chk("R6 R5 real hw exc", {info_o, rip_o}, {iw(8'd14, 3'd4, 1'b1), 32'h0FFF});
        exc_pend_i = 0; exc_has_err_i = 0; irq_new_i = 1; irq_ok_i = 1; irq_new_vec_i = 8'h21;
        strobe();
        chk("R6 real new irq", {info_o, rip_o}, {iw(8'h21, 3'd4, 1'b0), 32'h0FFF});
        irq_new_i = 0; irq_q_pend_i = 1; irq_q_soft_i = 1; irq_q_vec_i = 8'h80; exit_len_i = 4'd2;
        strobe();
        chk("R6 real soft irq rip", {info_o, rip_o}, {iw(8'h80, 3'd4, 1'b0), 32'h1001});
        clear_ins();
    endtask

    task automatic t_skip();
        shadow_wr_i = 1; shadow_sti_i = 1; shadow_movss_i = 1;
        @(negedge clk); shadow_wr_i = 0;
        chk("R12 both shadows set", {sti_sh_o, movss_sh_o}, 2'b11);
        rip_i = 32'h2000; exit_len_i = 4'd3; skip_i = 1;
        @(negedge clk); skip_i = 0;
        chk("R9 skip rip", rip_o, 32'h2003);
        chk("R9 skip clears shadows", {sti_sh_o, movss_sh_o}, 2'b00);
    endtask

    task automatic t_hold();
        clear_ins(); exc_pend_i = 1; exc_vec_i = 8'd8;
        strobe();
        exc_vec_i = 8'd9; irq_new_i = 1; irq_ok_i = 1;
        repeat (3) @(negedge clk);
        chk("R11 outputs hold without strobe", {info_o, irq_win_o}, {iw(8'd8, 3'd3, 1'b0), 1'b0});
        clear_ins();
        strobe();
        chk("R11 empty strobe", info_o, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_exceptions();
        t_priority();
        t_nmi_gate();
        t_soft_block();
        t_real_mode();
        t_skip();
        t_hold();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule